// File: doc/BRIEF.md
# Dual Parallel Port with Handshake

The block gives a processor two parallel ports, A and B, each `DW` bits wide (default 8). Software sets each port up through a small register file. A port can run in one of four ways:

- **Output.** The port drives its pins.
- **Input.** The port captures its pins.
- **Bidirectional.** Port A only.
- **Bit control.** Each pin has its own direction. Selected input pins are watched for a pattern.

Transfers with an outside device use a ready output and an active-low strobe input. Ready shows that the port can take part in a transfer. The falling edge of strobe marks that the device has finished one.

A port records an interrupt when a transfer completes or when its watched pattern first appears. This happens only if its enable bit is set. While anything is pending, the block holds `irq` high and shows the vector of the winning port. Port A wins over port B. An acknowledge pulse clears the port that is being shown. In bidirectional mode, port A sends data using its own ready/strobe pair. It receives data using port B's pair, so port B's pins must then be set to bit control.

The register address selects one of:

- 0 = data
- 1 = configuration
- 2 = direction
- 3 = mask
- 4 = vector

Configuration bits:

- bit 7 = interrupt enable
- bit 6 = AND matching (0 = OR)
- bit 5 = active-high level (0 = active-low)
- bits 1:0 = mode: 0 output, 1 input, 2 bidirectional, 3 bit control

Top module: `pp_dual`

## Requirements
- R1: After reset both ports are in input mode with ready high. All configuration, direction, mask, vector and data registers are zero, no output enable is set, and `irq` is low. Reading configuration returns 0x01.
- R2: Configuration reads back as {enable, AND, active-high, 000, mode}. A configuration write sets ready to 1 if the new mode is input and to 0 otherwise. A write of mode 2 to port B leaves B's mode unchanged but updates its other bits.
- R3: In output mode, all output enables are set. A data write raises ready. A strobe falling edge seen while ready is high clears ready and counts as a transfer event.
- R4: In input mode, no output enable is set. A strobe falling edge while ready is high latches the pins into the data register and clears ready. A read of the data register raises ready again.
- R5: A strobe falling edge while the port's ready is low is ignored: no latch and no event.
- R6: In bidirectional mode, port A drives its pins only while `stb_a_n` is low. `rdy_b` and `stb_b_n` handle reception into port A's data register, with the same rules as R4. Port B's own handshake does not react to its strobe.
- R7: In bit-control mode, a set direction bit makes that pin an input, and its output enable is cleared. A data read returns the pin for input bits and the written value for output bits.
- R8: In bit-control mode, only pins that are both input and mask=1 are watched. The pattern is active-high or active-low per configuration. OR mode needs any watched pin active; AND mode needs all of them and at least one watched. An event occurs only in the cycle the condition turns true.
- R9: An event sets a pending flag only if that port's enable bit is set. `irq` is high while any flag is set. `vector` shows the vector register of the granted port, or 0 when none is pending. `iack` clears the granted port's flag.
- R10: When both ports are pending, port A is granted and port B stays pending through an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_b | input | 1 | Register access targets port B (0 = port A) |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (re-arms input ready) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| pa_in | input | DW | Port A pin values |
| pa_out | output | DW | Port A output values |
| pa_oe | output | DW | Port A per-pin output enable |
| pb_in | input | DW | Port B pin values |
| pb_out | output | DW | Port B output values |
| pb_oe | output | DW | Port B per-pin output enable |
| stb_a_n | input | 1 | Port A strobe, active low |
| rdy_a | output | 1 | Port A ready |
| stb_b_n | input | 1 | Port B strobe (port A receive strobe in bidirectional mode) |
| rdy_b | output | 1 | Port B ready (port A receive ready in bidirectional mode) |
| iack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| vector | output | 8 | Vector of the granted port |

## Verification
The handshake is tried with single strobes, strobes repeated while ready is low, and strobes on port B's lines while port A is bidirectional. These separate an accepted transfer from an ignored one and show which port's lines are live. Pin patterns in bit-control mode are:

- a watched bit alone;
- an unwatched bit;
- an output bit;
- partial and full sets under AND;
- both level polarities.

Together these separate the mask, direction, AND/OR and level choices. Simultaneous strobes on both ports separate the fixed priority from a fair order.

// File: rtl/pp_pkg.sv
package pp_pkg;
   typedef enum logic [1:0] {
      PM_OUT   = 2'd0,
      PM_IN    = 2'd1,
      PM_BIDIR = 2'd2,
      PM_BIT   = 2'd3
   } pmode_t;

   localparam logic [2:0] ADR_DATA = 3'd0;
   localparam logic [2:0] ADR_CFG  = 3'd1;
   localparam logic [2:0] ADR_DIR  = 3'd2;
   localparam logic [2:0] ADR_MASK = 3'd3;
   localparam logic [2:0] ADR_VEC  = 3'd4;

   localparam int CFG_IE  = 7;
   localparam int CFG_AND = 6;
   localparam int CFG_HI  = 5;
endpackage

// File: rtl/pp_match.sv
module pp_match #(
   parameter int DW = 8
) (
   input  logic          en,
   input  logic [DW-1:0] pins,
   input  logic [DW-1:0] dir_in,
   input  logic [DW-1:0] mask,
   input  logic          and_sel,
   input  logic          act_hi,
   output logic          hit
);
   logic [DW-1:0] lvl, watched;
   logic          any_on, all_on;

   always_comb begin
      lvl     = act_hi ? pins : ~pins;
      watched = mask & dir_in;
      any_on  = |(lvl & watched);
      all_on  = (watched != '0) && ((lvl & watched) == watched);
      hit     = en & (and_sel ? all_on : any_on);
   end
endmodule

// File: rtl/pp_port.sv
module pp_port
   import pp_pkg::*;
#(
   parameter int DW        = 8,
   parameter bit HAS_BIDIR = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_data,
   input  logic          rd_data,
   input  logic          wr_cfg,
   input  logic          wr_dir,
   input  logic          wr_mask,
   input  logic          wr_vec,
   input  logic [7:0]    wdata,
   input  logic [DW-1:0] pin_in,
   input  logic          stb_n,
   input  logic          alt_stb_n,
   input  logic          lent,
   input  logic          ack,
   output logic [DW-1:0] pin_out,
   output logic [DW-1:0] pin_oe,
   output logic [DW-1:0] data_rd,
   output logic [DW-1:0] dir_q,
   output logic [DW-1:0] mask_q,
   output logic [7:0]    cfg_rd,
   output logic [7:0]    vec_q,
   output logic          rdy,
   output logic          alt_rdy,
   output logic          pend,
   output pmode_t        mode
);
   logic [DW-1:0] out_q, in_q;
   logic          ie_q, and_q, hi_q;
   logic          stb_q, alt_q, cond, cond_q;
   logic          fall, alt_fall, hs_ev, alt_ev, ev;
   pmode_t        new_mode;

   assign fall     = stb_q & ~stb_n & ~lent;
   assign alt_fall = alt_q & ~alt_stb_n;
   assign hs_ev    = fall & rdy & (mode != PM_BIT);
   assign alt_ev   = alt_fall & alt_rdy & (mode == PM_BIDIR);
   assign ev       = hs_ev | alt_ev | (cond & ~cond_q);
   assign new_mode = (!HAS_BIDIR && wdata[1:0] == PM_BIDIR) ? mode : pmode_t'(wdata[1:0]);

   pp_match #(.DW(DW)) u_match (
      .en(mode == PM_BIT), .pins(pin_in), .dir_in(dir_q), .mask(mask_q),
      .and_sel(and_q), .act_hi(hi_q), .hit(cond)
   );

   generate
      if (HAS_BIDIR) begin : g_alt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               alt_q   <= 1'b1;
               alt_rdy <= 1'b0;
            end else begin
               alt_q <= alt_stb_n;
               if (mode == PM_BIDIR) begin
                  if (alt_fall && alt_rdy) alt_rdy <= 1'b0;
                  if (rd_data)             alt_rdy <= 1'b1;
               end
               if (wr_cfg) alt_rdy <= (new_mode == PM_BIDIR);
            end
         end
      end else begin : g_noalt
         assign alt_q   = 1'b1;
         assign alt_rdy = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= PM_IN;
         rdy    <= 1'b1;
         ie_q   <= 1'b0;
         and_q  <= 1'b0;
         hi_q   <= 1'b0;
         out_q  <= '0;
         in_q   <= '0;
         dir_q  <= '0;
         mask_q <= '0;
         vec_q  <= '0;
         stb_q  <= 1'b1;
         cond_q <= 1'b0;
         pend   <= 1'b0;
      end else begin
         stb_q  <= stb_n;
         cond_q <= cond;
         if (mode == PM_OUT || mode == PM_BIDIR) begin
            if (fall && rdy) rdy <= 1'b0;
            if (wr_data)     rdy <= 1'b1;
         end
         if (mode == PM_IN) begin
            if (fall && rdy) begin
               in_q <= pin_in;
               rdy  <= 1'b0;
            end
            if (rd_data) rdy <= 1'b1;
         end
         if (alt_ev)  in_q   <= pin_in;
         if (wr_data) out_q  <= wdata[DW-1:0];
         if (wr_dir)  dir_q  <= wdata[DW-1:0];
         if (wr_mask) mask_q <= wdata[DW-1:0];
         if (wr_vec)  vec_q  <= wdata;
         if (wr_cfg) begin
            ie_q  <= wdata[CFG_IE];
            and_q <= wdata[CFG_AND];
            hi_q  <= wdata[CFG_HI];
            mode  <= new_mode;
            rdy   <= (new_mode == PM_IN);
         end
         if (ack)        pend <= 1'b0;
         if (ev && ie_q) pend <= 1'b1;
      end
   end

   always_comb begin
      pin_out = out_q;
      unique case (mode)
         PM_OUT:   begin pin_oe = '1;           data_rd = out_q; end
         PM_IN:    begin pin_oe = '0;           data_rd = in_q;  end
         PM_BIDIR: begin pin_oe = {DW{~stb_n}}; data_rd = in_q;  end
         default:  begin pin_oe = ~dir_q; data_rd = (pin_in & dir_q) | (out_q & ~dir_q); end
      endcase
      cfg_rd = {ie_q, and_q, hi_q, 3'b000, mode};
   end
endmodule

// File: rtl/pp_arb.sv
module pp_arb (
   input  logic       pend_a,
   input  logic       pend_b,
   input  logic [7:0] vec_a,
   input  logic [7:0] vec_b,
   input  logic       iack,
   output logic       irq,
   output logic [7:0] vector,
   output logic       ack_a,
   output logic       ack_b
);
   always_comb begin
      irq    = pend_a | pend_b;
      ack_a  = iack & pend_a;
      ack_b  = iack & ~pend_a & pend_b;
      vector = pend_a ? vec_a : (pend_b ? vec_b : 8'h00);
   end
endmodule

// File: rtl/pp_dual.sv
module pp_dual
   import pp_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_b,
   input  logic [2:0]    addr,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata,
   input  logic [DW-1:0] pa_in,
   output logic [DW-1:0] pa_out,
   output logic [DW-1:0] pa_oe,
   input  logic [DW-1:0] pb_in,
   output logic [DW-1:0] pb_out,
   output logic [DW-1:0] pb_oe,
   input  logic          stb_a_n,
   output logic          rdy_a,
   input  logic          stb_b_n,
   output logic          rdy_b,
   input  logic          iack,
   output logic          irq,
   output logic [7:0]    vector
);
   localparam int NP = 2;

   generate
      if (DW < 1 || DW > 8) begin : g_bad_dw
         $error("pp_dual: DW must be between 1 and 8");
      end
   endgenerate

   logic [DW-1:0] p_in [NP], p_out [NP], p_oe [NP], p_drd [NP], p_dir [NP], p_msk [NP];
   logic [7:0]    p_cfg [NP], p_vec [NP];
   logic          p_stb [NP], p_alt [NP], p_lent [NP], p_ack [NP];
   logic          p_rdy [NP], p_ardy [NP], p_pend [NP];
   pmode_t        p_mode [NP];
   logic          pend_a, pend_b;
   logic [1:0]    mode_a;
   logic [7:0]    rd_mux;

   assign p_in[0]  = pa_in;
   assign p_in[1]  = pb_in;
   assign p_stb[0] = stb_a_n;
   assign p_stb[1] = stb_b_n;
   assign p_alt[0] = stb_b_n;
   assign p_alt[1] = 1'b1;
   assign p_lent[0] = 1'b0;
   assign p_lent[1] = (p_mode[0] == PM_BIDIR);

   for (genvar i = 0; i < NP; i++) begin : g_port
      logic sel_i;
      assign sel_i = (sel_b == (i == 1));
      pp_port #(.DW(DW), .HAS_BIDIR(i == 0)) u_port (
         .clk(clk), .rst_n(rst_n),
         .wr_data(wr_en & sel_i & (addr == ADR_DATA)),
         .rd_data(rd_en & sel_i & (addr == ADR_DATA)),
         .wr_cfg (wr_en & sel_i & (addr == ADR_CFG)),
         .wr_dir (wr_en & sel_i & (addr == ADR_DIR)),
         .wr_mask(wr_en & sel_i & (addr == ADR_MASK)),
         .wr_vec (wr_en & sel_i & (addr == ADR_VEC)),
         .wdata(wdata), .pin_in(p_in[i]), .stb_n(p_stb[i]), .alt_stb_n(p_alt[i]),
         .lent(p_lent[i]), .ack(p_ack[i]),
         .pin_out(p_out[i]), .pin_oe(p_oe[i]), .data_rd(p_drd[i]),
         .dir_q(p_dir[i]), .mask_q(p_msk[i]), .cfg_rd(p_cfg[i]), .vec_q(p_vec[i]),
         .rdy(p_rdy[i]), .alt_rdy(p_ardy[i]), .pend(p_pend[i]), .mode(p_mode[i])
      );
   end

   pp_arb u_arb (
      .pend_a(p_pend[0]), .pend_b(p_pend[1]), .vec_a(p_vec[0]), .vec_b(p_vec[1]),
      .iack(iack), .irq(irq), .vector(vector), .ack_a(p_ack[0]), .ack_b(p_ack[1])
   );

   assign pend_a = p_pend[0];
   assign pend_b = p_pend[1];
   assign mode_a = p_mode[0];

   always_comb begin
      unique case (addr)
         ADR_DATA: rd_mux = 8'(p_drd[sel_b]);
         ADR_CFG:  rd_mux = p_cfg[sel_b];
         ADR_DIR:  rd_mux = 8'(p_dir[sel_b]);
         ADR_MASK: rd_mux = 8'(p_msk[sel_b]);
         ADR_VEC:  rd_mux = p_vec[sel_b];
         default:  rd_mux = 8'h00;
      endcase
   end

   assign rdata  = rd_mux;
   assign pa_out = p_out[0];
   assign pa_oe  = p_oe[0];
   assign pb_out = p_out[1];
   assign pb_oe  = p_oe[1];
   assign rdy_a  = p_rdy[0];
   assign rdy_b  = p_lent[1] ? p_ardy[0] : (p_rdy[1] | p_ardy[1]);
endmodule

// File: rtl/pp_dual_chk.sv
module pp_dual_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sel_b,
   input logic [2:0] addr,
   input logic       wr_en,
   input logic       rd_en,
   input logic       stb_a_n,
   input logic       stb_b_n,
   input logic       rdy_a,
   input logic       rdy_b,
   input logic       iack,
   input logic [1:0] mode_a,
   input logic       pend_a,
   input logic       pend_b
);
   p_strobe_clears_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_a == 2'd0 && rdy_a && $fell(stb_a_n) && !wr_en) |=> !rdy_a);

   p_read_rearms_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_a == 2'd1 && rd_en && !sel_b && addr == 3'd0 && !wr_en) |=> rdy_a);

   p_no_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_a == 2'd1 && !rdy_a && !rd_en && !wr_en) |=> !rdy_a);

   p_lent_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_a == 2'd2 && rdy_b && $fell(stb_b_n) && !wr_en) |=> !rdy_b);

   p_b_waits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (iack && pend_a && pend_b) |=> pend_b);
endmodule

bind pp_dual pp_dual_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sel_b(sel_b), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
   .stb_a_n(stb_a_n), .stb_b_n(stb_b_n), .rdy_a(rdy_a), .rdy_b(rdy_b), .iack(iack),
   .mode_a(mode_a), .pend_a(pend_a), .pend_b(pend_b)
);

// File: tb/sim_pp_dual.sv
module sim_pp_dual;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       sel_b = 1'b0, wr_en = 1'b0, rd_en = 1'b0, iack = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0, rdata, vector;
   logic [7:0] pa_in = '0, pb_in = '0, pa_out, pa_oe, pb_out, pb_oe;
   logic       stb_a_n = 1'b1, stb_b_n = 1'b1, rdy_a, rdy_b, irq;
   int         checks = 0, errors = 0;
   logic [7:0] rv;

   always #5 clk = ~clk;

   pp_dual #(.DW(8)) u0 (.*);

   // behavioural reference model
   int         m_mode [2] = '{1, 1};
   bit         m_ie [2], m_an [2], m_hi [2], m_pend [2], m_cq [2];
   bit         m_rdy [2] = '{1, 1}, m_sq [2] = '{1, 1};
   bit         m_ardy = 0;
   logic [7:0] m_out [2] = '{0, 0}, m_in [2] = '{0, 0}, m_dir [2] = '{0, 0};
   logic [7:0] m_msk [2] = '{0, 0}, m_vec [2] = '{0, 0};

   function automatic logic [7:0] pin_of(int p);
      return (p == 0) ? pa_in : pb_in;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < 2; p++) begin
            m_mode[p] = 1; m_rdy[p] = 1; m_ie[p] = 0; m_an[p] = 0; m_hi[p] = 0;
            m_pend[p] = 0; m_cq[p] = 0; m_sq[p] = 1; m_out[p] = 0; m_in[p] = 0;
            m_dir[p] = 0; m_msk[p] = 0; m_vec[p] = 0;
         end
         m_ardy = 0;
      end else begin
         int nmode [2]; bit nrdy [2], npend [2], ncq [2], nardy;
         logic [7:0] nin [2];
         bit ack [2];
         ack[0] = iack && m_pend[0];
         ack[1] = iack && !m_pend[0] && m_pend[1];
         nardy = m_ardy;
         for (int p = 0; p < 2; p++) begin
            bit sel, wrd, rdd, f, lent, ev, c;
            logic [7:0] lvl, w;
            sel  = (int'(sel_b) == p);
            wrd  = wr_en && sel && addr == 0;
            rdd  = rd_en && sel && addr == 0;
            f    = m_sq[p] && !((p == 0) ? stb_a_n : stb_b_n);
            lent = (p == 1 && m_mode[0] == 2);
            ev = 0; nrdy[p] = m_rdy[p]; nin[p] = m_in[p]; nmode[p] = m_mode[p];
            if (m_mode[p] == 0 || m_mode[p] == 2) begin
               if (f && m_rdy[p] && !lent) begin nrdy[p] = 0; ev = 1; end
               if (wrd) nrdy[p] = 1;
            end
            if (m_mode[p] == 1) begin
               if (f && m_rdy[p] && !lent) begin nin[p] = pin_of(p); nrdy[p] = 0; ev = 1; end
               if (rdd) nrdy[p] = 1;
            end
            if (m_mode[p] == 2) begin
               if (m_sq[1] && !stb_b_n && m_ardy) begin nin[p] = pin_of(p); nardy = 0; ev = 1; end
               if (rdd) nardy = 1;
            end
            c = 0;
            if (m_mode[p] == 3) begin
               lvl = m_hi[p] ? pin_of(p) : ~pin_of(p);
               w   = m_msk[p] & m_dir[p];
               c   = m_an[p] ? (w != 0 && (lvl & w) == w) : ((lvl & w) != 0);
            end
            if (c && !m_cq[p]) ev = 1;
            ncq[p] = c;
            npend[p] = m_pend[p];
            if (ack[p]) npend[p] = 0;
            if (ev && m_ie[p]) npend[p] = 1;
            if (wrd) m_out[p] = wdata;
            if (wr_en && sel && addr == 2) m_dir[p] = wdata;
            if (wr_en && sel && addr == 3) m_msk[p] = wdata;
            if (wr_en && sel && addr == 4) m_vec[p] = wdata;
            if (wr_en && sel && addr == 1) begin
               if (!(p == 1 && wdata[1:0] == 2)) nmode[p] = int'(wdata[1:0]);
               nrdy[p] = (nmode[p] == 1);
               if (p == 0) nardy = (nmode[p] == 2);
            end
         end
         for (int p = 0; p < 2; p++) begin
            if (wr_en && int'(sel_b) == p && addr == 1) begin
               m_ie[p] = wdata[7]; m_an[p] = wdata[6]; m_hi[p] = wdata[5];
            end
            m_mode[p] = nmode[p]; m_rdy[p] = nrdy[p]; m_pend[p] = npend[p];
            m_cq[p] = ncq[p]; m_in[p] = nin[p];
         end
         m_ardy = nardy;
         m_sq[0] = stb_a_n; m_sq[1] = stb_b_n;
      end
   end

   function automatic logic [7:0] m_oe(int p);
      case (m_mode[p])
         0: return 8'hFF;
         1: return 8'h00;
         2: return {8{~stb_a_n}};
         default: return ~m_dir[p];
      endcase
   endfunction

   function automatic logic [7:0] m_rd();
      int p = int'(sel_b);
      case (addr)
         0: return (m_mode[p] == 0) ? m_out[p] : (m_mode[p] == 3) ?
                   ((pin_of(p) & m_dir[p]) | (m_out[p] & ~m_dir[p])) : m_in[p];
         1: return {m_ie[p], m_an[p], m_hi[p], 3'b000, 2'(m_mode[p])};
         2: return m_dir[p];
         3: return m_msk[p];
         4: return m_vec[p];
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check("R3 rdy_a model", 8'(rdy_a), 8'(m_rdy[0]));
         check("R6 rdy_b model", 8'(rdy_b), 8'(m_mode[0] == 2 ? m_ardy : m_rdy[1]));
         check("R9 irq model", 8'(irq), 8'(m_pend[0] | m_pend[1]));
         check("R10 vector model", vector, m_pend[0] ? m_vec[0] : (m_pend[1] ? m_vec[1] : 8'h00));
         check("R7 pa_oe model", pa_oe, m_oe(0));
         check("R7 pb_oe model", pb_oe, m_oe(1));
         check("R3 pa_out model", pa_out, m_out[0]);
         check("R3 pb_out model", pb_out, m_out[1]);
         check("R2 rdata model", rdata, m_rd());
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic bus_wr(bit b, logic [2:0] a, logic [7:0] d);
      @(negedge clk); #1;
      sel_b = b; addr = a; wdata = d; wr_en = 1;
      @(negedge clk); #1;
      wr_en = 0;
   endtask

   task automatic bus_rd(bit b, logic [2:0] a, output logic [7:0] d);
      @(negedge clk); #1;
      sel_b = b; addr = a; rd_en = 1;
      #2 d = rdata;
      @(negedge clk); #1;
      rd_en = 0;
   endtask

   task automatic strobe(bit a_line, bit b_line);
      @(negedge clk); #1;
      if (a_line) stb_a_n = 0;
      if (b_line) stb_b_n = 0;
      @(negedge clk); #1;
      stb_a_n = 1; stb_b_n = 1;
   endtask

   task automatic ack_pulse();
      @(negedge clk); #1;
      iack = 1;
      @(negedge clk); #1;
      iack = 0;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      // R1 reset state
      check("R1 rdy_a", 8'(rdy_a), 8'd1);
      check("R1 rdy_b", 8'(rdy_b), 8'd1);
      check("R1 pa_oe", pa_oe, 8'h00);
      check("R1 irq", 8'(irq), 8'd0);
      bus_rd(0, 1, rv); check("R1 cfg A", rv, 8'h01);

      // R3 output mode with interrupt
      bus_wr(0, 4, 8'h40);
      bus_wr(1, 4, 8'h82);
      bus_wr(0, 1, 8'h80);
      check("R2 rdy_a after out cfg", 8'(rdy_a), 8'd0);
      check("R3 pa_oe", pa_oe, 8'hFF);
      bus_wr(0, 0, 8'h5A);
      check("R3 rdy_a after write", 8'(rdy_a), 8'd1);
      check("R3 pa_out", pa_out, 8'h5A);
      strobe(1, 0);
      check("R3 rdy_a after strobe", 8'(rdy_a), 8'd0);
      check("R9 irq", 8'(irq), 8'd1);
      check("R9 vector A", vector, 8'h40);
      ack_pulse();
      check("R9 irq cleared", 8'(irq), 8'd0);
      // R5 strobe with ready low ignored
      strobe(1, 0);
      cyc(1);
      check("R5 no event", 8'(irq), 8'd0);

      // R4 input on B, enable off
      bus_wr(1, 1, 8'h01);
      pb_in = 8'h3C;
      strobe(0, 1);
      check("R4 rdy_b cleared", 8'(rdy_b), 8'd0);
      check("R9 no irq when disabled", 8'(irq), 8'd0);
      bus_rd(1, 0, rv); check("R4 latched", rv, 8'h3C);
      check("R4 rdy_b rearmed", 8'(rdy_b), 8'd1);
      pb_in = 8'h11; strobe(0, 1);
      pb_in = 8'h22; strobe(0, 1);
      bus_rd(1, 0, rv); check("R5 second strobe ignored", rv, 8'h11);

      // R2 mode 2 rejected on B
      bus_wr(1, 1, 8'h02);
      bus_rd(1, 1, rv); check("R2 B keeps mode", rv, 8'h01);

      // R6 bidirectional A
      bus_wr(1, 1, 8'h03);
      bus_wr(0, 1, 8'h82);
      check("R6 rdy_b is A receive ready", 8'(rdy_b), 8'd1);
      check("R6 pa_oe idle", pa_oe, 8'h00);
      @(negedge clk); #1; stb_a_n = 0; #1;
      check("R6 pa_oe while strobe", pa_oe, 8'hFF);
      @(negedge clk); #1; stb_a_n = 1;
      pa_in = 8'h99;
      strobe(0, 1);
      check("R6 rdy_b cleared", 8'(rdy_b), 8'd0);
      check("R6 irq", 8'(irq), 8'd1);
      bus_rd(0, 0, rv); check("R6 received", rv, 8'h99);
      check("R6 rdy_b rearmed", 8'(rdy_b), 8'd1);
      ack_pulse();

      // R7/R8 bit control on A: OR, active high
      pa_in = 8'h00;
      bus_wr(0, 2, 8'hF0);
      bus_wr(0, 3, 8'h30);
      bus_wr(0, 1, 8'hA3);
      check("R7 pa_oe", pa_oe, 8'h0F);
      cyc(1);
      check("R8 quiet", 8'(irq), 8'd0);
      pa_in = 8'h40; cyc(2);
      check("R8 unwatched bit", 8'(irq), 8'd0);
      bus_rd(0, 0, rv); check("R7 mixed read", rv, 8'h4A);
      pa_in = 8'h08; cyc(2);
      check("R8 output bit ignored", 8'(irq), 8'd0);
      pa_in = 8'h10; cyc(2);
      check("R8 OR hit", 8'(irq), 8'd1);
      ack_pulse(); cyc(1);
      check("R8 edge only", 8'(irq), 8'd0);
      // AND
      pa_in = 8'h00;
      bus_wr(0, 1, 8'hE3);
      pa_in = 8'h10; cyc(2);
      check("R8 AND partial", 8'(irq), 8'd0);
      pa_in = 8'h30; cyc(2);
      check("R8 AND full", 8'(irq), 8'd1);
      ack_pulse();
      // OR active low
      bus_wr(0, 1, 8'h83);
      cyc(2);
      check("R8 low none", 8'(irq), 8'd0);
      pa_in = 8'h20; cyc(2);
      check("R8 low hit", 8'(irq), 8'd1);
      ack_pulse();

      // R10 priority
      bus_wr(0, 1, 8'h80);
      bus_wr(1, 1, 8'h80);
      bus_wr(0, 0, 8'h01);
      bus_wr(1, 0, 8'h02);
      strobe(1, 1);
      check("R10 vector A first", vector, 8'h40);
      ack_pulse();
      check("R10 B still pending", 8'(irq), 8'd1);
      check("R10 vector B", vector, 8'h82);
      ack_pulse();
      check("R9 all cleared", 8'(irq), 8'd0);

      cyc(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule